// File: doc/BRIEF.md
# Sample-Hold Pulse Timing Generator

This block turns a sampling request into two hold strobes for a converter front end. The first strobe marks the data-level hold and has a programmable high time. The second marks the feed-through-level hold; it is high for one converter clock period, and a code sets where it falls. The block counts converter rising edges while the request is high. The last of those edges is the reference. A pulse that spans too many edges is rejected and flagged.

The logic runs on a clock at twice the converter rate so that half-period widths can be produced. The input `edge_en` is high on every other fast-clock edge. It marks the fast edges that coincide with converter rising edges, called "ticks" below. The "qualifying tick" is the first tick that sees the request low after one to three ticks that saw it high. The strobe falling point is only known once the request has dropped. For that reason the strobes are produced with a fixed latency of `LAT_PERIODS` converter periods (8 fast cycles by default). Each rising edge can then be placed backwards from its falling edge. All timings below count fast cycles from the qualifying edge; "k" is the number of fast edges since that edge.

Top module: `shp_timing_gen`

## Requirements
- R1: During and right after reset, `shd`, `shr` and `err` are low.
- R2: A request that is seen high on 1, 2 or 3 consecutive ticks is accepted. It is accepted at the first later tick that sees it low, the qualifying tick, and its strobes then start.
- R3: `shd` falls exactly 8 fast cycles (4 converter periods) after the qualifying edge, on a tick, whatever the mode and code.
- R4: With `dbl_edge`=0 (single-edge mode), `shd` is high for 2*(`shd_code`+1) fast cycles, that is 1 to 4 periods, ending at the R3 falling point.
- R5: With `dbl_edge`=1 (double-edge mode), `shd` is high for `shd_code`+1 fast cycles, that is 0.5 to 2 periods, ending at the R3 falling point.
- R6: `shr` is high for exactly 2 fast cycles (one period). It falls 8 + 2*(`shr_code`+2) fast cycles after the qualifying edge, which places the fall 2 to 5 periods after the qualifying tick plus the fixed latency.
- R7: If a request is seen high on a 4th tick, `err` rises at that tick and no strobes are made for that pulse. `err` stays high until the next qualifying edge clears it.
- R8: Request activity while strobes are in progress is ignored, including a request still high when they finish. Counting restarts only after a tick sees the request low with no strobe pending.
- R9: Mode and codes are captured at the qualifying edge. Changing them while strobes are in progress does not alter those strobes.
- R10: `shd` and `shr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the converter clock rate |
| rst | input | 1 | Synchronous active-high reset |
| edge_en | input | 1 | High on fast edges that are converter rising edges (every other cycle) |
| samp_req | input | 1 | Sampling request level |
| dbl_edge | input | 1 | 0 = single-edge mode, 1 = double-edge mode |
| shd_code | input | 2 | Data-level strobe width code |
| shr_code | input | 2 | Feed-through strobe fall-delay code |
| shd | output | 1 | Data-level hold strobe |
| shr | output | 1 | Feed-through-level hold strobe |
| err | output | 1 | Invalid request flag (4 or more ticks high) |

## Verification
Requests one, two and three ticks long are applied with every width and delay code in both modes. The full output window is compared cycle by cycle, which separates a wrong reference edge (the whole pattern shifts) from a wrong width or delay code (only one edge moves). Pulses of four and six ticks check that rejection begins exactly at the fourth edge, and a valid pulse after an error checks that the flag clears. Requests held across the end of a strobe sequence, and configuration changes during one, show whether the block re-arms early or reads its settings late.

// File: rtl/shp_pkg.sv
package shp_pkg;

    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  dbl;    // 1: half-period width steps
        code_t wcode;  // data-level strobe width
        code_t dcode;  // feed-through strobe delay
    } hold_cfg_t;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_COUNT,
        Q_HOLD
    } qual_state_t;

    // Data-level strobe high time in fast-clock cycles.
    function automatic int unsigned shd_span_hc(input hold_cfg_t c);
        int unsigned steps;
        steps = int'(c.wcode) + 1;
        return c.dbl ? steps : 2 * steps;
    endfunction

    // Feed-through strobe fall offset (fast cycles) beyond the fixed latency.
    function automatic int unsigned shr_delay_hc(input hold_cfg_t c);
        return 2 * (int'(c.dcode) + 2);
    endfunction

endpackage

// File: rtl/shp_edge_qual.sv
module shp_edge_qual
    import shp_pkg::*;
#(
    parameter int MAX_EDGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_en,
    input  logic req,
    input  logic busy,
    output logic fire,
    output logic err
);

    localparam int EW = $clog2(MAX_EDGES + 2);

    qual_state_t    state;
    logic [EW-1:0]  n_edges;

    // The first tick seeing the request low after a valid run is the reference.
    assign fire = (state == Q_COUNT) && edge_en && !req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= Q_IDLE;
            n_edges <= '0;
            err     <= 1'b0;
        end else begin
            unique case (state)
                Q_IDLE: begin
                    if (edge_en && req && !busy) begin
                        state   <= Q_COUNT;
                        n_edges <= EW'(1);
                    end
                end
                Q_COUNT: begin
                    if (edge_en) begin
                        if (req) begin
                            if (n_edges == EW'(MAX_EDGES)) begin
                                err   <= 1'b1;
                                state <= Q_HOLD;
                            end else begin
                                n_edges <= n_edges + EW'(1);
                            end
                        end else begin
                            err   <= 1'b0;
                            state <= Q_HOLD;
                        end
                    end
                end
                Q_HOLD: begin
                    if (edge_en && !req && !busy) begin
                        state   <= Q_IDLE;
                        n_edges <= '0;
                    end
                end
                default: state <= Q_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shp_strobe_timer.sv
module shp_strobe_timer
    import shp_pkg::*;
#(
    parameter int LAT_PERIODS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  hold_cfg_t cfg_in,
    output logic      busy,
    output logic      shd,
    output logic      shr
);

    localparam int LAT_HC  = 2 * LAT_PERIODS;
    localparam int MAX_FALL = LAT_HC + 2 * ((1 << CODE_W) + 1);
    localparam int CNT_W   = $clog2(MAX_FALL + 1);

    hold_cfg_t        cfg_q;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span_hc;
    logic [CNT_W-1:0] fall_hc;
    logic [CNT_W-1:0] shd_rise;

    assign span_hc  = CNT_W'(shd_span_hc(cfg_q));
    assign fall_hc  = CNT_W'(LAT_HC) + CNT_W'(shr_delay_hc(cfg_q));
    assign shd_rise = CNT_W'(LAT_HC) - span_hc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            cfg_q  <= '0;
        end else if (fire) begin
            active <= 1'b1;
            cnt    <= '0;
            cfg_q  <= cfg_in;
        end else if (active) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == fall_hc - CNT_W'(1)) begin
                active <= 1'b0;
            end
        end
    end

    assign busy = active;
    assign shd  = active && (cnt >= shd_rise) && (cnt < CNT_W'(LAT_HC));
    assign shr  = active && (cnt >= fall_hc - CNT_W'(2)) && (cnt < fall_hc);

endmodule

// File: rtl/shp_timing_gen.sv
module shp_timing_gen
    import shp_pkg::*;
#(
    parameter int LAT_PERIODS = 4,
    parameter int MAX_EDGES   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_en,
    input  logic              samp_req,
    input  logic              dbl_edge,
    input  logic [CODE_W-1:0] shd_code,
    input  logic [CODE_W-1:0] shr_code,
    output logic              shd,
    output logic              shr,
    output logic              err
);

    hold_cfg_t cfg_now;
    logic      fire;
    logic      busy;

    assign cfg_now = '{dbl: dbl_edge, wcode: shd_code, dcode: shr_code};

    shp_edge_qual #(
        .MAX_EDGES(MAX_EDGES)
    ) i_qual (
        .clk    (clk),
        .rst    (rst),
        .edge_en(edge_en),
        .req    (samp_req),
        .busy   (busy),
        .fire   (fire),
        .err    (err)
    );

    shp_strobe_timer #(
        .LAT_PERIODS(LAT_PERIODS)
    ) i_timer (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .cfg_in(cfg_now),
        .busy  (busy),
        .shd   (shd),
        .shr   (shr)
    );

endmodule

// File: rtl/shp_timing_chk.sv
module shp_timing_chk (
    input logic clk,
    input logic rst,
    input logic edge_en,
    input logic samp_req,
    input logic shd,
    input logic shr,
    input logic err
);

    // R3: the data-level strobe always ends on a converter rising edge
    p_shd_fall_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(shd) |-> $past(edge_en));

    // R6: feed-through strobe lasts two fast cycles
    p_shr_min_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(shr) |=> shr);

    p_shr_max_r6: assert property (@(posedge clk) disable iff (rst)
        (shr && $past(shr)) |=> !shr);

    // R7: error only raised at a tick that saw the request high
    p_err_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(edge_en) && $past(samp_req)));

    // R7: no strobes while a rejected pulse is flagged
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> (!shd && !shr));

    // R10: strobes never overlap
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        !(shd && shr));

endmodule

bind shp_timing_gen shp_timing_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .edge_en (edge_en),
    .samp_req(samp_req),
    .shd     (shd),
    .shr     (shr),
    .err     (err)
);

// File: tb/test_shp_timing_gen.sv
module test_shp_timing_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       edge_en = 1'b0;
    logic       samp_req = 1'b0;
    logic       dbl_edge = 1'b0;
    logic [1:0] shd_code = 2'd0;
    logic [1:0] shr_code = 2'd0;
    logic       shd;
    logic       shr;
    logic       err;

    int  checks = 0;
    int  errors = 0;
    bit  ph = 1'b1;

    always #2 clk = ~clk;   // 250 MHz fast clock

    shp_timing_gen i_shp_timing_gen (
        .clk     (clk),
        .rst     (rst),
        .edge_en (edge_en),
        .samp_req(samp_req),
        .dbl_edge(dbl_edge),
        .shd_code(shd_code),
        .shr_code(shr_code),
        .shd     (shd),
        .shr     (shr),
        .err     (err)
    );

    function automatic bit exp_shd(int k, bit dbl, int wc);
        int span;
        span = dbl ? wc + 1 : 2 * (wc + 1);
        return (k >= 8 - span) && (k < 8);
    endfunction

    function automatic bit exp_shr(int k, int dc);
        int fall;
        fall = 8 + 2 * (dc + 2);
        return (k >= fall - 2) && (k < fall);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one fast cycle; sample 1 ns after the edge.
    task automatic step(input logic r);
        samp_req = r;
        edge_en  = ph;
        ph       = ~ph;
        @(posedge clk);
        #1;
    endtask

    task automatic run_pulse(input int n, input bit dbl, input int wc, input int dc,
                             input bit busy_req, input bit chg, input string lbl);
        bit valid;
        string t_shd, t_shr, t_err;
        valid    = (n <= 3);
        dbl_edge = dbl;
        shd_code = 2'(wc);
        shr_code = 2'(dc);
        for (int i = 0; i < 4; i++) step(1'b0);
        if (!ph) step(1'b0);
        for (int i = 1; i <= n; i++) begin
            step(1'b1);
            if (i == 4) chk("R7 err at 4th tick", int'(err), 1);
            step(1'b1);
        end
        step(1'b0);   // qualifying tick
        for (int k = 0; k <= 30; k++) begin
            if (k > 0) step(busy_req && k >= 2 && k <= 21);
            if (chg && k == 3) begin
                dbl_edge = ~dbl_edge;
                shd_code = ~shd_code;
                shr_code = shr_code + 2'd1;
            end
            if (lbl != "")        t_shd = lbl;
            else if (k == 8)      t_shd = "R3 shd fall";
            else if (dbl)         t_shd = "R5 shd double";
            else                  t_shd = "R4 shd single";
            t_shr = (lbl != "") ? lbl : "R6 shr";
            t_err = valid ? "R7 err cleared" : "R7 err held";
            chk(t_shd, int'(shd), valid ? int'(exp_shd(k, dbl, wc)) : 0);
            chk(t_shr, int'(shr), valid ? int'(exp_shr(k, dc)) : 0);
            chk(t_err, int'(err), valid ? 0 : 1);
            chk("R10 overlap", int'(shd && shr), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0411));
        repeat (3) step(1'b0);
        chk("R1 shd in reset", int'(shd), 0);
        chk("R1 shr in reset", int'(shr), 0);
        chk("R1 err in reset", int'(err), 0);
        rst = 1'b0;
        step(1'b0);
        chk("R1 shd after reset", int'(shd), 0);
        chk("R1 shr after reset", int'(shr), 0);
        chk("R1 err after reset", int'(err), 0);

        // R2: one, two and three tick requests
        run_pulse(1, 1'b0, 0, 0, 1'b0, 1'b0, "R2 one tick");
        run_pulse(3, 1'b0, 3, 3, 1'b0, 1'b0, "R2 three ticks");
        run_pulse(2, 1'b0, 1, 2, 1'b0, 1'b0, "");
        run_pulse(2, 1'b0, 2, 1, 1'b0, 1'b0, "");
        // R5: every double-edge width
        for (int w = 0; w < 4; w++) run_pulse(2, 1'b1, w, w, 1'b0, 1'b0, "");
        // R7: rejection, then recovery
        run_pulse(4, 1'b0, 1, 1, 1'b0, 1'b0, "R7 four ticks");
        run_pulse(6, 1'b1, 2, 0, 1'b0, 1'b0, "R7 six ticks");
        run_pulse(1, 1'b0, 3, 2, 1'b0, 1'b0, "R7 recovery");
        // R8: request held across the strobe sequence
        run_pulse(2, 1'b0, 3, 3, 1'b1, 1'b0, "R8 ignored request");
        run_pulse(1, 1'b1, 0, 1, 1'b0, 1'b0, "R8 re-armed");
        // R9: configuration changed mid-sequence
        run_pulse(2, 1'b0, 1, 0, 1'b0, 1'b1, "R9 latched config");
        run_pulse(3, 1'b1, 3, 3, 1'b0, 1'b1, "R9 latched config");

        for (int s = 0; s < 30; s++) begin
            int n;
            n = ($urandom_range(0, 9) == 0) ? int'($urandom_range(4, 5))
                                             : int'($urandom_range(1, 3));
            run_pulse(n, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
                      ($urandom_range(0, 3) == 0), "");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule